// File: doc/BRIEF.md
# Capture/Reload Timer with Baud Output

This block is a 16-bit up-counter with a companion 16-bit capture/reload register. It advances on every clock or on each falling edge of an external count pin, depending on its source select bit. When the count passes 0xFFFF it either wraps to zero or reloads from the companion register. A falling edge on an external trigger pin can also capture the running count or force a reload. Two sticky flags, one for overflow and one for external events, drive an interrupt request. These flags clear only through a register write.

The block can also serve as a baud-rate source for two serial ports. Each of the four clock outputs (receive and transmit for ports A and B) carries either the timer's overflow pulse or an alternate overflow input, as its select bit chooses. Once any of the four selects is set, the timer always runs in auto-reload mode: the overflow flag stays quiet and the trigger pin is ignored. A byte-wide register port gives access to the control byte, the counter and the capture/reload register.

Top module: `crt_timer`

## Requirements
- R1: After a synchronous reset, every register reads 0x00 and `irq_o`, `ovf_pulse_o` and `baud_clk_o` are 0.
- R2: Register map: address 0 is the control byte, addresses 1/2 are the counter low/high bytes and addresses 3/4 are the capture/reload low/high bytes. Other addresses read 0x00. `reg_rdata` returns the addressed value one cycle after the address is presented. A write to a counter byte replaces that byte, keeps the other byte and overrides counting in that cycle.
- R3: The control byte bits are 7 overflow flag, 6 external flag, 5 port-A receive select, 4 port-A transmit select, 3 trigger enable, 2 run, 1 count source, 0 capture mode. With run=1 and count source=0 the counter increments each clock. With count source=1 it increments once per falling edge of `ext_count_in`, seen after a two-flop synchronizer. With run=0 it holds.
- R4: In capture mode with no serial select set, a counting step at 0xFFFF wraps the counter to 0x0000 and sets the overflow flag.
- R5: With capture mode=0, a counting step at 0xFFFF loads the capture/reload register into the counter in the same cycle and sets the overflow flag.
- R6: With capture mode=1 and trigger enable=1, a synchronized falling edge of `ext_trig_in` copies the current count into the capture/reload register, sets the external flag, and counting goes on. A capture wins over a same-cycle software write to that register.
- R7: With capture mode=0 and trigger enable=1, a synchronized falling edge of `ext_trig_in` loads the counter from the capture/reload register and sets the external flag.
- R8: With trigger enable=0, edges on `ext_trig_in` change neither the counter, the capture/reload register nor any flag.
- R9: While any of bits 5, 4, `b_rx_sel` or `b_tx_sel` is 1, the timer auto-reloads on overflow whatever the capture mode bit says, the overflow flag is not set, and the trigger pin has no effect.
- R10: `ovf_pulse_o` is high for one cycle, one cycle after each overflow. Each bit of `baud_clk_o` (0 A receive, 1 A transmit, 2 B receive, 3 B transmit) carries that pulse when its select is 1. Otherwise it carries `alt_ovf_in` delayed by one cycle.
- R11: Flags are set by hardware and take the written value on a control write. A write wins over a hardware set in the same cycle. `irq_o` is the OR of the two flags and updates in the same cycle as they do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| ext_count_in | input | 1 | External count pin (falling edges counted) |
| ext_trig_in | input | 1 | External capture/reload trigger pin |
| alt_ovf_in | input | 1 | Alternate overflow pulse for unselected serial clocks |
| b_rx_sel | input | 1 | Port B receive clock select |
| b_tx_sel | input | 1 | Port B transmit clock select |
| baud_clk_o | output | 4 | Serial clock pulses: A rx, A tx, B rx, B tx |
| ovf_pulse_o | output | 1 | One-cycle pulse after each overflow |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a control write that clears the overflow flag in the very cycle the counter overflows. The stimulus presets the counter to 0xFFFE with a byte write and then sets the run bit. Counting from register writes, it issues the clearing write on the exact edge where the count leaves 0xFFFF. The serial-select override is hit in a similar way. The counter is parked a few counts below 0xFFFF with capture mode and trigger enable both set, and trigger pulses arrive while a select from each port is active. A behavioural model checks every output on every cycle.

// File: rtl/crt_pkg.sv
package crt_pkg;
  localparam int CTRL_W     = 8;
  localparam int B_FLAG_OVF = 7;
  localparam int B_FLAG_EXT = 6;
  localparam int B_A_RX     = 5;
  localparam int B_A_TX     = 4;
  localparam int B_TRIG_EN  = 3;
  localparam int B_RUN      = 2;
  localparam int B_SRC      = 1;
  localparam int B_CAP      = 0;
  localparam int N_BAUD     = 4;
endpackage

// File: rtl/crt_fall_detect.sv
module crt_fall_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_in,
  output logic fall_o
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], pin_in};
  end

  // previous sampled level high, current sampled level low
  assign fall_o = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/crt_counter.sv
module crt_counter #(
  parameter int W  = 16,
  parameter int DW = 8,
  localparam int NB = W / DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          cnt_src,
  input  logic          cnt_fall,
  input  logic          cap_mode,
  input  logic          trig_evt,
  input  logic [NB-1:0] cnt_be,
  input  logic [NB-1:0] rl_be,
  input  logic [DW-1:0] wdata,
  output logic [W-1:0]  cnt_q,
  output logic [W-1:0]  rl_q,
  output logic          ovf
);
  logic         tick;
  logic [W-1:0] cnt_d, rl_d;

  assign tick = run & (cnt_src ? cnt_fall : 1'b1);
  assign ovf  = tick & (&cnt_q);

  always_comb begin
    cnt_d = cnt_q;
    if (trig_evt && !cap_mode)  cnt_d = rl_q;
    else if (ovf)               cnt_d = cap_mode ? '0 : rl_q;
    else if (tick)              cnt_d = cnt_q + 1'b1;
    if (|cnt_be) begin
      cnt_d = cnt_q;
      for (int b = 0; b < NB; b++)
        if (cnt_be[b]) cnt_d[b*DW +: DW] = wdata;
    end
  end

  always_comb begin
    rl_d = rl_q;
    if (trig_evt && cap_mode) rl_d = cnt_q;
    else
      for (int b = 0; b < NB; b++)
        if (rl_be[b]) rl_d[b*DW +: DW] = wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      rl_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      rl_q  <= rl_d;
    end
  end

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !trig_evt && !(|cnt_be)) |=> cnt_q == $past(cnt_q));
  // R5
  ovf_reload_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf && !cap_mode && !trig_evt && !(|cnt_be)) |=> cnt_q == $past(rl_q));
  // R6
  capture_chk: assert property (@(posedge clk) disable iff (rst)
    (trig_evt && cap_mode) |=> rl_q == $past(cnt_q));
endmodule

// File: rtl/crt_ctrl.sv
module crt_ctrl
  import crt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              ovf_set,
  input  logic              ext_set,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              irq
);
  logic [CTRL_W-1:0] ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr) begin
      ctrl_d = wdata;
    end else begin
      if (ovf_set) ctrl_d[B_FLAG_OVF] = 1'b1;
      if (ext_set) ctrl_d[B_FLAG_EXT] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      irq    <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      irq    <= ctrl_d[B_FLAG_OVF] | ctrl_d[B_FLAG_EXT];
    end
  end

  // R11
  ext_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (ext_set && !wr) |=> (ctrl_q[B_FLAG_EXT] && irq));
  // R11
  wr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && !wdata[B_FLAG_OVF]) |=> !ctrl_q[B_FLAG_OVF]);
endmodule

// File: rtl/crt_timer.sv
module crt_timer
  import crt_pkg::*;
#(
  parameter int W         = 16,
  parameter int DW        = 8,
  parameter int AW        = 3,
  parameter int SYNC_STGS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              ext_count_in,
  input  logic              ext_trig_in,
  input  logic              alt_ovf_in,
  input  logic              b_rx_sel,
  input  logic              b_tx_sel,
  output logic [N_BAUD-1:0] baud_clk_o,
  output logic              ovf_pulse_o,
  output logic              irq_o
);
  localparam int NB      = W / DW;
  localparam int CNT_LO  = 1;
  localparam int RL_LO   = CNT_LO + NB;

  logic [CTRL_W-1:0] ctrl_q;
  logic [W-1:0]      cnt_q, rl_q;
  logic [NB-1:0]     cnt_be, rl_be;
  logic              cnt_fall, trig_fall, ovf, serial, trig_evt, cap_eff, ctrl_wr;
  logic [N_BAUD-1:0] sel;
  logic [DW-1:0]     rd_d;

  assign ctrl_wr  = reg_wr && (reg_addr == AW'(0));
  assign sel      = {b_tx_sel, b_rx_sel, ctrl_q[B_A_TX], ctrl_q[B_A_RX]};
  assign serial   = |sel;
  assign cap_eff  = ctrl_q[B_CAP] & ~serial;
  assign trig_evt = ctrl_q[B_TRIG_EN] & trig_fall & ~serial;

  for (genvar b = 0; b < NB; b++) begin : g_be
    assign cnt_be[b] = reg_wr && (reg_addr == AW'(CNT_LO + b));
    assign rl_be[b]  = reg_wr && (reg_addr == AW'(RL_LO + b));
  end

  crt_fall_detect #(.STAGES(SYNC_STGS)) u_cnt_sync (
    .clk(clk), .rst(rst), .pin_in(ext_count_in), .fall_o(cnt_fall));
  crt_fall_detect #(.STAGES(SYNC_STGS)) u_trig_sync (
    .clk(clk), .rst(rst), .pin_in(ext_trig_in), .fall_o(trig_fall));

  crt_counter #(.W(W), .DW(DW)) u_counter (
    .clk(clk), .rst(rst),
    .run(ctrl_q[B_RUN]), .cnt_src(ctrl_q[B_SRC]), .cnt_fall(cnt_fall),
    .cap_mode(cap_eff), .trig_evt(trig_evt),
    .cnt_be(cnt_be), .rl_be(rl_be), .wdata(reg_wdata),
    .cnt_q(cnt_q), .rl_q(rl_q), .ovf(ovf));

  crt_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wr(ctrl_wr), .wdata(reg_wdata[CTRL_W-1:0]),
    .ovf_set(ovf & ~serial), .ext_set(trig_evt),
    .ctrl_q(ctrl_q), .irq(irq_o));

  always_comb begin
    rd_d = '0;
    if (reg_addr == AW'(0)) rd_d = DW'(ctrl_q);
    for (int b = 0; b < NB; b++) begin
      if (reg_addr == AW'(CNT_LO + b)) rd_d = cnt_q[b*DW +: DW];
      if (reg_addr == AW'(RL_LO + b))  rd_d = rl_q[b*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata   <= '0;
      ovf_pulse_o <= 1'b0;
    end else begin
      reg_rdata   <= rd_d;
      ovf_pulse_o <= ovf;
    end
  end

  for (genvar i = 0; i < N_BAUD; i++) begin : g_baud
    always_ff @(posedge clk) begin
      if (rst) baud_clk_o[i] <= 1'b0;
      else     baud_clk_o[i] <= sel[i] ? ovf : alt_ovf_in;
    end
  end

  // R9
  serial_noflag_chk: assert property (@(posedge clk) disable iff (rst)
    (serial && !ctrl_wr && !ctrl_q[B_FLAG_OVF]) |=> !ctrl_q[B_FLAG_OVF]);
  // R10
  ovf_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf_pulse_o);
  // R10
  baud_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (sel[0] && ovf) |=> baud_clk_o[0]);
  // R8
  trig_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[B_TRIG_EN] && !reg_wr) |=> $stable(rl_q));
endmodule

// File: tb/test_crt_timer.sv
module test_crt_timer;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       ext_count_in = 1'b1;
  logic       ext_trig_in = 1'b1;
  logic       alt_ovf_in = 1'b0;
  logic       b_rx_sel = 1'b0;
  logic       b_tx_sel = 1'b0;
  logic [3:0] baud_clk_o;
  logic       ovf_pulse_o, irq_o;

  crt_timer i_crt_timer (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ext_count_in(ext_count_in), .ext_trig_in(ext_trig_in),
    .alt_ovf_in(alt_ovf_in), .b_rx_sel(b_rx_sel), .b_tx_sel(b_tx_sel),
    .baud_clk_o(baud_clk_o), .ovf_pulse_o(ovf_pulse_o), .irq_o(irq_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 0;
  bit    started = 0;
  string cur_tag = "R1";

  // behavioural reference model
  int unsigned m_cnt, m_rl, m_ctrl, m_rdata;
  bit          m_irq, m_ovp;
  bit [3:0]    m_baud;
  bit          qc[$] = '{0, 0, 0};
  bit          qt[$] = '{0, 0, 0};

  always @(posedge clk) begin
    bit cf, tf, ser, tk, ov, ev, capm;
    int unsigned n_cnt, n_rl, n_ctrl;
    bit [3:0] s;
    started = 1;
    if (rst) begin
      m_cnt = 0; m_rl = 0; m_ctrl = 0; m_rdata = 0;
      m_irq = 0; m_ovp = 0; m_baud = 0;
      qc = '{0, 0, 0}; qt = '{0, 0, 0};
    end else begin
      cf   = qc[2] && !qc[1];
      tf   = qt[2] && !qt[1];
      s    = {b_tx_sel, b_rx_sel, m_ctrl[4] == 1'b1, m_ctrl[5] == 1'b1};
      ser  = (s != 0);
      tk   = m_ctrl[2] && (m_ctrl[1] ? cf : 1'b1);
      ov   = tk && (m_cnt == 32'hFFFF);
      ev   = m_ctrl[3] && tf && !ser;
      capm = m_ctrl[0] && !ser;
      case (reg_addr)
        3'd0: m_rdata = m_ctrl;
        3'd1: m_rdata = m_cnt % 256;
        3'd2: m_rdata = m_cnt / 256;
        3'd3: m_rdata = m_rl % 256;
        3'd4: m_rdata = m_rl / 256;
        default: m_rdata = 0;
      endcase
      n_cnt = m_cnt;
      if (reg_wr && reg_addr == 3'd1)      n_cnt = (m_cnt & 32'hFF00) | reg_wdata;
      else if (reg_wr && reg_addr == 3'd2) n_cnt = (m_cnt & 32'h00FF) | (reg_wdata * 256);
      else if (ev && !capm)                n_cnt = m_rl;
      else if (ov)                         n_cnt = capm ? 0 : m_rl;
      else if (tk)                         n_cnt = m_cnt + 1;
      n_rl = m_rl;
      if (ev && capm)                      n_rl = m_cnt;
      else if (reg_wr && reg_addr == 3'd3) n_rl = (m_rl & 32'hFF00) | reg_wdata;
      else if (reg_wr && reg_addr == 3'd4) n_rl = (m_rl & 32'h00FF) | (reg_wdata * 256);
      n_ctrl = m_ctrl;
      if (reg_wr && reg_addr == 3'd0) n_ctrl = reg_wdata;
      else begin
        if (ov && !ser) n_ctrl = n_ctrl | 32'h80;
        if (ev)         n_ctrl = n_ctrl | 32'h40;
      end
      m_ovp = ov;
      for (int i = 0; i < 4; i++) m_baud[i] = s[i] ? ov : alt_ovf_in;
      m_cnt = n_cnt; m_rl = n_rl; m_ctrl = n_ctrl;
      m_irq = (m_ctrl & 32'hC0) != 0;
      qc.push_front(ext_count_in); void'(qc.pop_back());
      qt.push_front(ext_trig_in);  void'(qt.pop_back());
    end
  end

  task automatic check(string tag, string what, int unsigned got, int unsigned exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, got, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (started && !done) begin
      check(cur_tag, "rdata", reg_rdata, m_rdata);
      check("R11", "irq", irq_o, m_irq);
      check("R10", "ovf_pulse", ovf_pulse_o, m_ovp);
      check("R10", "baud", baud_clk_o, m_baud);
    end
  end

  int poll = 0;
  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      reg_wr = 0; reg_addr = 3'(poll); poll = (poll + 1) % 5;
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    reg_wr = 1; reg_addr = 3'(a); reg_wdata = 8'(d);
  endtask

  task automatic rd(int a, output logic [7:0] v);
    @(negedge clk);
    reg_wr = 0; reg_addr = 3'(a);
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic pulse_cnt(int lo, int hi);
    for (int k = 0; k < lo; k++) begin idle(1); ext_count_in = 0; end
    for (int k = 0; k < hi; k++) begin idle(1); ext_count_in = 1; end
  endtask

  task automatic pulse_trig();
    idle(1); ext_trig_in = 0;
    idle(3); ext_trig_in = 1;
    idle(3);
  endtask

  initial begin
    repeat (CLK_PERIOD * 2000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    for (int a = 0; a < 5; a++) begin
      rd(a, v);
      check("R1", "reset reg", v, 0);
    end
    check("R1", "reset irq", irq_o, 0);

    // R2: register map access with the counter stopped
    cur_tag = "R2";
    wr(1, 'h34); wr(2, 'h12); wr(3, 'hCD); wr(4, 'hAB);
    idle(6);
    rd(2, v); check("R2", "cnt hi", v, 'h12);

    // R4: capture-mode wrap
    cur_tag = "R4";
    wr(1, 'hFA); wr(2, 'hFF); wr(0, 'h05);
    idle(12);
    wr(0, 'h81);
    rd(0, v); check("R4", "ovf flag set", v, 'h81);
    wr(0, 'h01);
    rd(0, v); check("R11", "flag cleared", v, 'h01);
    check("R11", "irq low after clear", irq_o, 0);

    // R11: clearing write in the same cycle as an overflow
    cur_tag = "R11";
    wr(1, 'hFE); wr(2, 'hFF); wr(0, 'h05);
    idle(1);
    wr(0, 'h04);
    rd(0, v); check("R11", "write beats set", v, 'h04);
    wr(0, 'h00);

    // R5: auto-reload
    cur_tag = "R5";
    wr(3, 'hF8); wr(4, 'hFF); wr(1, 'hF0); wr(2, 'hFF); wr(0, 'h04);
    idle(40);
    wr(0, 'h00);
    idle(3);

    // R3: external count source, then held with run=0
    cur_tag = "R3";
    wr(1, 'h00); wr(2, 'h00); wr(0, 'h06);
    for (int k = 0; k < 5; k++) pulse_cnt(2 + (k % 2), 2 + (k % 3));
    idle(4);
    wr(0, 'h02);
    rd(1, v); check("R3", "edges counted", v, 5);
    for (int k = 0; k < 3; k++) pulse_cnt(2, 2);
    idle(4);
    rd(1, v); check("R3", "held with run=0", v, 5);
    wr(0, 'h04); idle(7); wr(0, 'h00);

    // R6: capture on trigger
    cur_tag = "R6";
    wr(1, 'h00); wr(2, 'h00); wr(0, 'h0D);
    idle(5); pulse_trig(); idle(4); pulse_trig();
    rd(0, v); check("R6", "ext flag", v, 'h4D);

    // R7: reload on trigger
    cur_tag = "R7";
    wr(0, 'h0C); wr(3, 'h00); wr(4, 'h01);
    idle(6); pulse_trig();
    rd(0, v); check("R7", "ext flag", v, 'h4C);

    // R8: trigger disabled
    cur_tag = "R8";
    wr(0, 'h05);
    pulse_trig(); idle(3);
    rd(0, v); check("R8", "no flag", v, 'h05);

    // R9: serial override (port A receive, then port B transmit)
    cur_tag = "R9";
    wr(0, 'h00);
    wr(3, 'hF0); wr(4, 'hFF); wr(1, 'hF0); wr(2, 'hFF); wr(0, 'h2D);
    idle(10); pulse_trig(); idle(20); pulse_trig();
    rd(0, v); check("R9", "no flags in serial mode", v, 'h2D);
    b_tx_sel = 1;
    wr(0, 'h0D);
    idle(8); pulse_trig(); idle(20);
    rd(0, v); check("R9", "port B select override", v, 'h0D);
    b_tx_sel = 0;
    wr(0, 'h00);

    // R10: baud routing with alternate source
    cur_tag = "R10";
    wr(1, 'hF8); wr(2, 'hFF); wr(3, 'hFA); wr(4, 'hFF);
    b_rx_sel = 1;
    wr(0, 'h14);
    for (int k = 0; k < 30; k++) begin idle(1); alt_ovf_in = (k % 3 == 0); end
    b_rx_sel = 0; alt_ovf_in = 0;
    wr(0, 'h00);
    idle(4);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule